// File: doc/BRIEF.md
# Chip-Address Write Filter with Companion Address

This block sits between an SPI slave shifter and a register file. It decides whether a received write frame belongs to this device. The device address is 3 bits wide. Its two low bits are fixed at zero. Its top bit comes from an external strap pin, which is read once after every reset and then held. A completed frame is one where the shifter reports that the frame is done while chip select is still active. When the frame's chip field matches either the device's own address or a programmable companion address, the block issues a one-cycle register write strobe. The strobe carries the frame's register index and data.

The companion address lives in the low bits of one configuration register. That register sits at a fixed register index, and any accepted write to that index loads it. With a companion address set, a command sent to a partner device on the same bus also updates this device. When the companion register holds the device's own address, the second match adds nothing and the shared-command feature is off. The companion register starts at the sampled own address, so the feature is off after every reset.

Top module: `chipaddr_filter`

## Requirements
- R1: After capture completes, `own_addr` equals the strap pin value in bit 2 with bits 1 and 0 at zero. A strap pin at 1 gives 3'b100 and a strap pin at 0 gives 3'b000.
- R2: Once `addr_ready` is high, `own_addr` does not change until the next reset, even if the strap pin changes.
- R3: When `addr_ready` rises after reset, `comp_addr` equals `own_addr`.
- R4: A frame whose chip field equals `own_addr`, with `frame_done` and `cs_active` both high, gives `wr_stb` high for exactly one cycle. The strobe follows the clock edge that samples the frame. It carries `wr_reg` and `wr_data` equal to the frame's register index and data.
- R5: A frame whose chip field equals `comp_addr` but not `own_addr` is accepted in the same way as in R4.
- R6: A frame whose chip field matches neither address gives no strobe and leaves `comp_addr` unchanged.
- R7: A `frame_done` pulse while `cs_active` is low gives no strobe, even when the chip field matches.
- R8: An accepted write to register index 6'h09 loads `frame_data[2:0]` into `comp_addr`. The new value is visible after the same edge that raises the strobe.
- R9: When `comp_addr` is loaded with `own_addr`, frames to any other chip address are rejected, and frames to `own_addr` are still accepted.
- R10: While `addr_ready` is low, meaning the strap has not been captured, no frame produces a strobe. `addr_ready` rises three clock edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_pin | input | 1 | Strap pin for the top address bit |
| cs_active | input | 1 | Chip select is currently asserted |
| frame_done | input | 1 | Pulse: the shifter has completed a frame |
| frame_chip | input | 3 | Chip address field of the frame |
| frame_reg | input | 6 | Register index field of the frame |
| frame_data | input | 24 | Data field of the frame |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_reg | output | 6 | Register index for the strobe |
| wr_data | output | 24 | Data for the strobe |
| own_addr | output | 3 | Captured own chip address |
| comp_addr | output | 3 | Companion chip address register |
| addr_ready | output | 1 | The strap has been captured |

## Verification
A corrupted captured address shows up on `own_addr` after the capture edge. It also shows up as wrongly accepted or rejected frames on the cycle after each frame. A stuck or stale companion register is visible on `comp_addr` one edge after a write to index 6'h09. The next frame aimed at the companion then reveals it through a missing or extra strobe. A strobe gate that ignores chip select or capture readiness shows as a strobe on the very next cycle.

// File: rtl/chipaddr_pkg.sv
package chipaddr_pkg;
   typedef enum logic [0:0] {
      CAP_WAIT = 1'b0,
      CAP_DONE = 1'b1
   } cap_state_e;
endpackage

// File: rtl/chipaddr_capture.sv
module chipaddr_capture
   import chipaddr_pkg::*;
#(
   parameter int CHIP_W      = 3,
   parameter int FIXED_LOW   = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [CHIP_W-FIXED_LOW-1:0]   pin,
   output logic [CHIP_W-1:0]             own_addr,
   output logic                          ready,
   output logic                          cap_pulse
);
   localparam int HI_W  = CHIP_W - FIXED_LOW;
   localparam int CNT_W = $clog2(SYNC_STAGES + 1) + 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_STAGES);

   generate
      if (HI_W < 1) begin : g_bad_width
         $error("chipaddr_capture: at least one address bit must come from the pin");
      end
   endgenerate

   logic [HI_W-1:0]  pin_s;
   logic [HI_W-1:0]  hi_q;
   logic [CNT_W-1:0] cnt_q;
   cap_state_e       st_q;

   // Optional synchronizer stages ahead of the capture point
   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign pin_s = pin;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0][HI_W-1:0] sreg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sreg <= '{default: '1};
            end else begin
               sreg[0] <= pin;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  sreg[i] <= sreg[i-1];
               end
            end
         end
         assign pin_s = sreg[SYNC_STAGES-1];
      end
   endgenerate

   assign cap_pulse = (st_q == CAP_WAIT) && (cnt_q == CNT_LAST);
   assign ready     = (st_q == CAP_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= CAP_WAIT;
         cnt_q <= '0;
         hi_q  <= '1;
      end else if (st_q == CAP_WAIT) begin
         if (cnt_q == CNT_LAST) begin
            hi_q <= pin_s;
            st_q <= CAP_DONE;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   generate
      if (FIXED_LOW == 0) begin : g_all_pin
         assign own_addr = hi_q;
      end else begin : g_low_tied
         assign own_addr = {hi_q, {FIXED_LOW{1'b0}}};
      end
   endgenerate

   // R2: captured address is frozen once ready
   p_own_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && $past(ready)) |-> $stable(own_addr));

   // R10: readiness never drops without a reset
   p_ready_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);
endmodule

// File: rtl/chipaddr_match.sv
module chipaddr_match #(
   parameter int CHIP_W         = 3,
   parameter bit USE_COMPANION  = 1'b1
) (
   input  logic [CHIP_W-1:0] chip,
   input  logic [CHIP_W-1:0] own_addr,
   input  logic [CHIP_W-1:0] comp_addr,
   output logic              hit
);
   logic hit_own;
   logic hit_comp;

   assign hit_own = (chip == own_addr);

   generate
      if (USE_COMPANION) begin : g_comp
         assign hit_comp = (chip == comp_addr);
      end else begin : g_nocomp
         logic unused_comp;
         assign unused_comp = ^comp_addr;
         assign hit_comp    = 1'b0 & unused_comp;
      end
   endgenerate

   assign hit = hit_own | hit_comp;

   // R6: a hit always equals one of the two addresses
   always_comb begin
      if (hit) begin
         a_hit_source_r6: assert ((chip == own_addr) || (USE_COMPANION && chip == comp_addr));
      end
   end
endmodule

// File: rtl/chipaddr_comp_reg.sv
module chipaddr_comp_reg #(
   parameter int CHIP_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_load,
   input  logic [CHIP_W-1:0] init_val,
   input  logic              wr_en,
   input  logic [CHIP_W-1:0] wr_val,
   output logic [CHIP_W-1:0] comp_addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         comp_addr <= '1;
      end else if (init_load) begin
         comp_addr <= init_val;
      end else if (wr_en) begin
         comp_addr <= wr_val;
      end
   end

   // R8/R6: value only moves on an init load or an accepted write
   p_comp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_load && !wr_en) |=> $stable(comp_addr));

   // R8: accepted write lands on the next edge
   p_comp_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !init_load) |=> (comp_addr == $past(wr_val)));
endmodule

// File: rtl/chipaddr_filter.sv
module chipaddr_filter #(
   parameter int          CHIP_W        = 3,
   parameter int          FIXED_LOW     = 2,
   parameter int          SYNC_STAGES   = 2,
   parameter int          REG_AW        = 6,
   parameter int          DATA_W        = 24,
   parameter int          COMP_REG      = 9,
   parameter bit          USE_COMPANION = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [CHIP_W-FIXED_LOW-1:0] addr_pin,
   input  logic                        cs_active,
   input  logic                        frame_done,
   input  logic [CHIP_W-1:0]           frame_chip,
   input  logic [REG_AW-1:0]           frame_reg,
   input  logic [DATA_W-1:0]           frame_data,
   output logic                        wr_stb,
   output logic [REG_AW-1:0]           wr_reg,
   output logic [DATA_W-1:0]           wr_data,
   output logic [CHIP_W-1:0]           own_addr,
   output logic [CHIP_W-1:0]           comp_addr,
   output logic                        addr_ready
);
   localparam logic [REG_AW-1:0] COMP_IDX = REG_AW'(COMP_REG);

   generate
      if (DATA_W < CHIP_W) begin : g_bad_data
         $error("chipaddr_filter: data field narrower than chip address");
      end
      if (COMP_REG >= (1 << REG_AW)) begin : g_bad_idx
         $error("chipaddr_filter: companion register index out of range");
      end
   endgenerate

   logic cap_pulse;
   logic hit;
   logic accept;
   logic comp_wr;

   chipaddr_capture #(
      .CHIP_W      (CHIP_W),
      .FIXED_LOW   (FIXED_LOW),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin       (addr_pin),
      .own_addr  (own_addr),
      .ready     (addr_ready),
      .cap_pulse (cap_pulse)
   );

   chipaddr_match #(
      .CHIP_W        (CHIP_W),
      .USE_COMPANION (USE_COMPANION)
   ) u_match (
      .chip      (frame_chip),
      .own_addr  (own_addr),
      .comp_addr (comp_addr),
      .hit       (hit)
   );

   assign accept  = addr_ready & frame_done & cs_active & hit;
   assign comp_wr = accept & (frame_reg == COMP_IDX);

   chipaddr_comp_reg #(
      .CHIP_W (CHIP_W)
   ) u_comp (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_load (cap_pulse),
      .init_val  ({frame_chip & '0} | {u_cap.pin_s, {FIXED_LOW{1'b0}}}),
      .wr_en     (comp_wr),
      .wr_val    (frame_data[CHIP_W-1:0]),
      .comp_addr (comp_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_stb  <= 1'b0;
         wr_reg  <= '0;
         wr_data <= '0;
      end else begin
         wr_stb <= accept;
         if (accept) begin
            wr_reg  <= frame_reg;
            wr_data <= frame_data;
         end
      end
   end

   // R4/R7: a strobe needs a completed frame under chip select
   p_stb_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> $past(frame_done && cs_active));

   // R10: no strobe while capture is incomplete
   p_ready_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_ready |=> !wr_stb);

   // R6: frame to a foreign address is dropped
   p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && frame_chip != own_addr && frame_chip != comp_addr) |=> !wr_stb);

   // R3: companion starts equal to own address
   p_comp_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(addr_ready) |-> (comp_addr == own_addr));
endmodule

// File: tb/tb_chipaddr_filter.sv
module tb_chipaddr_filter;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [0:0]  addr_pin = 1'b1;
   logic        cs_active = 1'b0;
   logic        frame_done = 1'b0;
   logic [2:0]  frame_chip = '0;
   logic [5:0]  frame_reg = '0;
   logic [23:0] frame_data = '0;
   logic        wr_stb;
   logic [5:0]  wr_reg;
   logic [23:0] wr_data;
   logic [2:0]  own_addr;
   logic [2:0]  comp_addr;
   logic        addr_ready;

   int checks = 0;
   int fails  = 0;

   chipaddr_filter dut (
      .clk (clk), .rst_n (rst_n), .addr_pin (addr_pin),
      .cs_active (cs_active), .frame_done (frame_done),
      .frame_chip (frame_chip), .frame_reg (frame_reg), .frame_data (frame_data),
      .wr_stb (wr_stb), .wr_reg (wr_reg), .wr_data (wr_data),
      .own_addr (own_addr), .comp_addr (comp_addr), .addr_ready (addr_ready)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Reset with a strap value, then wait for capture (R10 timing)
   task automatic do_reset(input logic pin);
      int n;
      addr_pin = pin;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(addr_ready == 1'b0 && wr_stb == 1'b0, "R10 reset state", {wr_stb, addr_ready}, 0);
      rst_n = 1'b1;
      n = 0;
      while (!addr_ready && n < 20) begin
         @(negedge clk);
         n++;
      end
      check(n == 3, "R10 capture latency", n, 3);
   endtask

   // Returns strobe seen after the sampling edge and strobe one cycle later
   task automatic send(input logic [2:0] chip, input logic [5:0] rg, input logic [23:0] dat,
                       input logic cs, output logic stb1, output logic stb2);
      frame_chip = chip; frame_reg = rg; frame_data = dat;
      cs_active = cs; frame_done = 1'b1;
      @(negedge clk);
      stb1 = wr_stb;
      frame_done = 1'b0; cs_active = 1'b0;
      @(negedge clk);
      stb2 = wr_stb;
   endtask

   task automatic t_not_ready;
      logic s1, s2;
      addr_pin = 1'b1;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      send(3'b100, 6'h01, 24'h1, 1'b1, s1, s2);
      check(s1 == 1'b0 && s2 == 1'b0, "R10 frame before capture", {s1, s2}, 0);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_capture_high;
      do_reset(1'b1);
      check(own_addr == 3'b100, "R1 own address pin=1", own_addr, 3'b100);
      check(comp_addr == 3'b100, "R3 companion init pin=1", comp_addr, 3'b100);
      addr_pin = 1'b0;
      repeat (6) @(negedge clk);
      check(own_addr == 3'b100, "R2 pin change ignored", own_addr, 3'b100);
   endtask

   task automatic t_own_write;
      logic s1, s2;
      send(3'b100, 6'h2A, 24'hABCDEF, 1'b1, s1, s2);
      check(s1 == 1'b1, "R4 strobe on own frame", s1, 1);
      check(s2 == 1'b0, "R4 strobe single cycle", s2, 0);
      check(wr_reg == 6'h2A && wr_data == 24'hABCDEF, "R4 strobe payload", {wr_reg, wr_data}, {6'h2A, 24'hABCDEF});
   endtask

   task automatic t_rejects;
      logic s1, s2;
      send(3'b011, 6'h09, 24'h000005, 1'b1, s1, s2);
      check(s1 == 1'b0, "R6 foreign frame rejected", s1, 0);
      check(comp_addr == 3'b100, "R6 companion untouched", comp_addr, 3'b100);
      send(3'b100, 6'h03, 24'h55, 1'b0, s1, s2);
      check(s1 == 1'b0, "R7 no chip select", s1, 0);
   endtask

   task automatic t_companion;
      logic s1, s2;
      send(3'b100, 6'h09, 24'hFFFF03, 1'b1, s1, s2);
      check(comp_addr == 3'b011, "R8 companion loaded", comp_addr, 3'b011);
      send(3'b011, 6'h10, 24'h123456, 1'b1, s1, s2);
      check(s1 == 1'b1 && wr_reg == 6'h10 && wr_data == 24'h123456, "R5 companion frame accepted",
            {s1, wr_reg, wr_data}, {1'b1, 6'h10, 24'h123456});
      send(3'b101, 6'h10, 24'h1, 1'b1, s1, s2);
      check(s1 == 1'b0 && comp_addr == 3'b011, "R6 third address rejected", {s1, comp_addr}, 3'b011);
   endtask

   task automatic t_disable;
      logic s1, s2;
      send(3'b011, 6'h09, 24'h000004, 1'b1, s1, s2);
      check(comp_addr == 3'b100, "R8 companion set to own", comp_addr, 3'b100);
      send(3'b011, 6'h10, 24'h2, 1'b1, s1, s2);
      check(s1 == 1'b0, "R9 old companion rejected", s1, 0);
      send(3'b100, 6'h11, 24'h3, 1'b1, s1, s2);
      check(s1 == 1'b1, "R9 own still accepted", s1, 1);
   endtask

   task automatic t_capture_low;
      logic s1, s2;
      do_reset(1'b0);
      check(own_addr == 3'b000, "R1 own address pin=0", own_addr, 3'b000);
      check(comp_addr == 3'b000, "R3 companion init pin=0", comp_addr, 3'b000);
      send(3'b100, 6'h01, 24'h1, 1'b1, s1, s2);
      check(s1 == 1'b0, "R1 old address rejected", s1, 0);
      send(3'b000, 6'h01, 24'h7, 1'b1, s1, s2);
      check(s1 == 1'b1 && wr_data == 24'h7, "R4 strobe at address 0", {s1, wr_data}, {1'b1, 24'h7});
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      t_not_ready();
      t_capture_high();
      t_own_write();
      t_rejects();
      t_companion();
      t_disable();
      t_capture_low();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule